// File: doc/BRIEF.md
# Watchdog Countdown Timer with Byte Register Port

This block is a system watchdog. A six-bit countdown value drops by one on every slow tick. The tick comes from a prescaler whose length in clock cycles is a parameter. Software keeps the system alive by writing the reload register before the count runs out. That write copies the programmed timeout back into the counter and restarts the prescaler. Reading the same register returns the live count.

When the count runs out for the first time, the block:
- sets a first-expiry flag,
- pulses an interrupt for one cycle,
- reloads the counter and keeps going.

If the count runs out again before software clears that flag, the block sets a second-expiry flag. It also raises a reboot request, unless the no-reboot mask bit is set. In that case it raises a suppressed flag instead.

A halt bit in the upper control byte freezes both the counter and the prescaler. After reset the timer is halted and reboots are masked, so nothing fires until software enables the timer. All registers are one byte wide and sit behind a plain address / write-strobe / read-strobe port. Read data is registered.

Register map (byte address):
- 0: reload / live count
- 1: timeout
- 2: control low byte
- 3: control high byte (halt at bit 3)
- 4: status 1 (first expiry at bit 3)
- 5: status 2 (bit 1 second expiry, bit 0 suppressed reboot)
- 6: configuration (no-reboot at bit 1)
- 7: unmapped

Top module: `wdt_regblock`

## Requirements
- R1: After reset the registers read as follows:
  - timeout reads 8;
  - live count reads 8;
  - control high byte reads 0x08 (halt set);
  - configuration reads 0x02 (no-reboot set);
  - both status registers read 0;
  - irq and reboot_req are low.
- R2: A write to address 1 with a code of 4 or more in bits 5:0 stores that code. Bits 7:6 of the write are dropped, and address 1 always reads with bits 7:6 as 0.
- R3: A write to address 1 whose bits 5:0 hold 0, 1, 2 or 3 leaves the stored timeout unchanged.
- R4: Any write to address 0 loads the counter from the stored timeout and restarts the prescaler at zero.
- R5: A read of address 0 returns the live count in bits 5:0 and 0 in bits 7:6.
- R6: While bit 3 of address 3 is 1, the counter and prescaler hold. Addresses 2 and 3 read back exactly the byte last written.
- R7: While running, the count drops by one every PRESCALE_CYC clock cycles, counted from the write that cleared halt or from a reload.
- R8: When a tick would take the count from 1 to 0 and status-1 bit 3 is clear, three things happen on the same edge:
  - status-1 bit 3 is set;
  - irq is high for exactly one cycle;
  - the count is reloaded from the timeout.

  From a reload or un-halt, this edge comes T×PRESCALE_CYC cycles later, where T is the timeout.
- R9: An expiry while status-1 bit 3 is already set sets status-2 bit 1. If configuration bit 1 is 0, it also raises reboot_req, which then stays high.
- R10: If configuration bit 1 is 1 at that second expiry, reboot_req stays low and status-2 bit 0 is set.
- R11: Status bits are write-one-to-clear. Writing 0 changes nothing. Writing 0x03 to address 5 clears both of its flags and drops reboot_req.
- R12: rd_data changes only on a clock edge where rd_en is high. It shows the addressed register from that edge. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; captures the addressed byte |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | One-cycle pulse on first expiry |
| reboot_req | output | 1 | Sticky reboot request on unmasked second expiry |

## Verification
The bench sweeps all 64 timeout codes with the upper bits set. A design that accepts codes 0–3, or stores bits 7:6, reads back a value the arithmetic model does not expect.

For timeouts 4 through 12, the bench counts the exact cycle from un-halt to the interrupt and then to the reboot request. An off-by-one in the prescaler compare, or an expiry taken at a count of 0 instead of 1, moves that cycle by PRESCALE_CYC.

The bench halts the timer at chosen points and reads the live count. This exposes a counter that keeps running while halted or that decrements on the wrong edge. It alternates the no-reboot mask and writes zero and one patterns to the status registers. A design that ignores the mask, clears flags on a zero write, or keeps reboot_req after the clear shows the wrong status byte or output level.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TMO_W  = 6;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIMEOUT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT1   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT2   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CFG     = 3'd6;

  localparam int HALT_BIT     = 3;
  localparam int NOREBOOT_BIT = 1;
  localparam int FIRST_BIT    = 3;
  localparam int SECOND_BIT   = 1;
  localparam int MASKED_BIT   = 0;

  localparam logic [TMO_W-1:0] TMO_MIN = 6'd4;

  // Codes below the minimum are rejected by the timeout register.
  function automatic logic tmo_legal(input logic [TMO_W-1:0] code);
    return code >= TMO_MIN;
  endfunction

  // True when the next tick would bring the count to zero.
  function automatic logic at_last_step(input logic [TMO_W-1:0] cnt);
    return cnt <= TMO_W'(1);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE_CYC > 1) ? $clog2(PRESCALE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE_CYC - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
  end

  assign tick = run && !restart && (pre_q == LAST);

  // R6: a halted prescaler keeps its phase
  assert_pre_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pre_q));
  // R4: reload restarts the prescaler phase
  assert_pre_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter logic [TMO_W-1:0] DEF_TMO = 6'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [TMO_W-1:0] tmo,
  output logic [TMO_W-1:0] count,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  assign expire = tick && !reload && at_last_step(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= DEF_TMO;
    else if (reload) cnt_q <= tmo;
    else if (expire) cnt_q <= tmo;
    else if (tick)   cnt_q <= cnt_q - TMO_W'(1);
  end

  assign count = cnt_q;

  // R7: one step down per tick
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && cnt_q > TMO_W'(1)) |=> (cnt_q == $past(cnt_q) - TMO_W'(1)));
  // R8: expiry reloads from the timeout
  assert_expire_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(tmo)));
  // R4: reload strobe loads the timeout
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(tmo)));
  // R6: no tick and no reload means the count holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [TMO_W-1:0] DEF_TMO = 6'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [TMO_W-1:0]  count,
  input  logic              expire,
  output logic [DATA_W-1:0] rd_data,
  output logic [TMO_W-1:0]  tmo,
  output logic              halt,
  output logic              reload_wr,
  output logic              irq,
  output logic              reboot_req
);
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] ctrl_lo_q, ctrl_hi_q;
  logic              noreboot_q, first_q, second_q, masked_q, irq_q, reboot_q;
  logic [DATA_W-1:0] rd_q, rd_mux;

  logic wr_tmo, wr_clo, wr_chi, wr_st1, wr_st2, wr_cfg;
  logic first_set, second_set, masked_set, reboot_set;
  logic first_clr, second_clr, masked_clr;

  assign reload_wr = wr_en && (addr == A_RELOAD);
  assign wr_tmo    = wr_en && (addr == A_TIMEOUT);
  assign wr_clo    = wr_en && (addr == A_CTRL_LO);
  assign wr_chi    = wr_en && (addr == A_CTRL_HI);
  assign wr_st1    = wr_en && (addr == A_STAT1);
  assign wr_st2    = wr_en && (addr == A_STAT2);
  assign wr_cfg    = wr_en && (addr == A_CFG);

  // Expiry classification: first one flags, a repeat escalates.
  assign first_set  = expire && !first_q;
  assign second_set = expire &&  first_q;
  assign masked_set = second_set &&  noreboot_q;
  assign reboot_set = second_set && !noreboot_q;

  assign first_clr  = wr_st1 && wdata[FIRST_BIT];
  assign second_clr = wr_st2 && wdata[SECOND_BIT];
  assign masked_clr = wr_st2 && wdata[MASKED_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q      <= DEF_TMO;
      ctrl_lo_q  <= '0;
      ctrl_hi_q  <= DATA_W'(1) << HALT_BIT;
      noreboot_q <= 1'b1;
      first_q    <= 1'b0;
      second_q   <= 1'b0;
      masked_q   <= 1'b0;
      irq_q      <= 1'b0;
      reboot_q   <= 1'b0;
    end else begin
      if (wr_tmo && tmo_legal(wdata[TMO_W-1:0])) tmo_q <= wdata[TMO_W-1:0];
      if (wr_clo) ctrl_lo_q <= wdata;
      if (wr_chi) ctrl_hi_q <= wdata;
      if (wr_cfg) noreboot_q <= wdata[NOREBOOT_BIT];
      first_q  <= (first_q  && !first_clr)  || first_set;
      second_q <= (second_q && !second_clr) || second_set;
      masked_q <= (masked_q && !masked_clr) || masked_set;
      reboot_q <= (reboot_q && !second_clr) || reboot_set;
      irq_q    <= first_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_RELOAD:  rd_mux = {{(DATA_W-TMO_W){1'b0}}, count};
      A_TIMEOUT: rd_mux = {{(DATA_W-TMO_W){1'b0}}, tmo_q};
      A_CTRL_LO: rd_mux = ctrl_lo_q;
      A_CTRL_HI: rd_mux = ctrl_hi_q;
      A_STAT1:   rd_mux = DATA_W'(first_q) << FIRST_BIT;
      A_STAT2:   rd_mux = (DATA_W'(second_q) << SECOND_BIT) | (DATA_W'(masked_q) << MASKED_BIT);
      A_CFG:     rd_mux = DATA_W'(noreboot_q) << NOREBOOT_BIT;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data    = rd_q;
  assign tmo        = tmo_q;
  assign halt       = ctrl_hi_q[HALT_BIT];
  assign irq        = irq_q;
  assign reboot_req = reboot_q;

  // R3: illegal codes leave the timeout alone
  assert_tmo_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo && !tmo_legal(wdata[TMO_W-1:0])) |=> $stable(tmo_q));
  // R10: reboot request never rises while masked
  assert_mask_reboot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reboot_q) |-> !$past(noreboot_q));
  // R8: interrupt is a single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R11: writing zero to a status bit keeps it set
  assert_w1c_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st1 && !wdata[FIRST_BIT] && first_q) |=> first_q);
  // R12: read data moves only on a read strobe
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/wdt_regblock.sv
module wdt_regblock
  import wdt_pkg::*;
#(
  parameter int               PRESCALE_CYC = 600,
  parameter logic [TMO_W-1:0] DEF_TMO      = 6'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              reboot_req
);
  logic             tick, expire, halt, reload_wr;
  logic [TMO_W-1:0] tmo, count;

  wdt_prescaler #(.PRESCALE_CYC(PRESCALE_CYC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_wr), .tick(tick)
  );

  wdt_counter #(.DEF_TMO(DEF_TMO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_wr),
    .tmo(tmo), .count(count), .expire(expire)
  );

  wdt_regs #(.DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .count(count), .expire(expire), .rd_data(rd_data),
    .tmo(tmo), .halt(halt), .reload_wr(reload_wr), .irq(irq),
    .reboot_req(reboot_req)
  );

  // R9: a reboot request only rises on an expiry edge
  assert_reboot_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reboot_req) |-> $past(expire));
  // R6: no tick while halted
  assert_halt_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !tick);
endmodule

// File: tb/tb_wdt_regblock.sv
module tb_wdt_regblock;
  localparam int P   = 4;
  localparam int DEF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq, reboot_req;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  wdt_regblock #(.PRESCALE_CYC(P), .DEF_TMO(6'(DEF))) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .reboot_req(reboot_req)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // Arithmetic model of the timeout register.
  function automatic int tmo_model(input int prev, input int code);
    return (code >= 4) ? code : prev;
  endfunction

  initial begin
    logic [7:0] v;
    int prev;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R1 irq", irq, 0);
    chk("R1 reboot_req", reboot_req, 0);
    rd(3'd1, v); chk("R1 timeout", v, DEF);
    rd(3'd0, v); chk("R1 count", v, DEF);
    rd(3'd3, v); chk("R1 ctrl_hi", v, 8'h08);
    rd(3'd6, v); chk("R1 cfg", v, 8'h02);
    rd(3'd4, v); chk("R1 stat1", v, 0);
    rd(3'd5, v); chk("R1 stat2", v, 0);

    // Exhaustive timeout code sweep, upper bits set in every write
    prev = DEF;
    for (int c = 0; c < 64; c++) begin
      wr(3'd1, {2'b11, 6'(c)});
      prev = tmo_model(prev, c);
      rd(3'd1, v);
      if (c < 4) chk("R3 reject", v, prev);
      else       chk("R2 accept", v, prev);
    end

    // Control bytes read back; unmapped address reads zero
    wr(3'd2, 8'hA5); rd(3'd2, v); chk("R6 ctrl_lo", v, 8'hA5);
    wr(3'd3, 8'hF8); rd(3'd3, v); chk("R6 ctrl_hi", v, 8'hF8);
    wr(3'd3, 8'h08); rd(3'd3, v); chk("R6 ctrl_hi halt", v, 8'h08);
    rd(3'd7, v); chk("R12 unmapped", v, 0);
    @(negedge clk); addr = 3'd1;
    repeat (3) @(negedge clk);
    chk("R12 hold", rd_data, 0);

    // Halted reload and count readback
    wr(3'd1, 8'd10); wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R4 R5 reload", v, 10);
    repeat (40) @(negedge clk);
    rd(3'd0, v); chk("R6 frozen", v, 10);

    // Step counting: un-halt, run m = k*P+1 cycles, halt, read the count
    wr(3'd1, 8'd9);
    for (int k = 1; k < 9; k++) begin
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h00);
      repeat (k * P - 1) @(negedge clk);
      wr(3'd3, 8'h08);
      rd(3'd0, v); chk("R7 steps", v, 9 - k);
    end

    // Expiry timing and escalation for a range of timeouts
    for (int t = 4; t <= 12; t++) begin
      logic masked;
      masked = t[0];
      wr(3'd3, 8'h08);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      wr(3'd6, masked ? 8'h02 : 8'h00);
      wr(3'd1, 8'(t));
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h00);
      n = 0;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
      chk("R8 first expiry cycle", n, t * P);
      @(negedge clk);
      chk("R8 irq pulse", irq, 0);
      n = 1;
      while (n < t * P) begin @(negedge clk); n++; end
      chk(masked ? "R10 masked reboot" : "R9 reboot", reboot_req, masked ? 0 : 1);
      chk("R8 no second irq", irq, 0);
      wr(3'd3, 8'h08);
      rd(3'd4, v); chk("R8 stat1", v, 8'h08);
      rd(3'd5, v); chk(masked ? "R10 stat2" : "R9 stat2", v, masked ? 8'h03 : 8'h02);
      wr(3'd5, 8'h00);
      rd(3'd5, v); chk("R11 zero write stat2", v, masked ? 8'h03 : 8'h02);
      chk("R11 reboot kept", reboot_req, masked ? 0 : 1);
      wr(3'd4, 8'h00);
      rd(3'd4, v); chk("R11 zero write stat1", v, 8'h08);
      wr(3'd5, 8'h03);
      rd(3'd5, v); chk("R11 stat2 cleared", v, 0);
      chk("R11 reboot dropped", reboot_req, 0);
      wr(3'd4, 8'h08);
      rd(3'd4, v); chk("R11 stat1 cleared", v, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule